// File: doc/BRIEF.md
# Nibble Adder/Subtractor with BCD and Excess-3 Conversion

This block is a combinational arithmetic unit for 4-bit operands. A single mode input selects addition or subtraction. Subtraction is done in two's complement: each bit of the second operand is XORed with the mode bit, and the mode bit also feeds the carry into the least significant stage. One flag output carries the adder carry-out when adding. When subtracting, it carries a borrow indication, formed by XORing the raw carry with the mode bit.

A second select input replaces the second operand with the constant three. With that select high, the same adder turns a BCD digit into its Excess-3 code when adding. When subtracting, it turns an Excess-3 code back into a BCD digit. Inputs outside the valid code range are not trapped: they give the plain modulo-16 result and the usual flag. The block has no clock or storage, and its outputs follow the inputs through the ripple chain.

Top module: `nibble_addsub_conv`

## Requirements
- R1: With sub_mode=0 and conv_en=0, result equals (a_in + b_in) mod 16 and flag equals bit 4 of the 5-bit sum a_in + b_in.
- R2: With sub_mode=1 and conv_en=0, result equals (a_in - b_in) mod 16, i.e. a_in plus the inverted b_in plus one.
- R3: With sub_mode=1, flag is 1 exactly when a_in is below the selected second operand (unsigned), and 0 otherwise.
- R4: A subtraction whose minuend is below the subtrahend leaves the result in two's-complement form: 1110 minus 1111 gives result 1111 with flag 1.
- R5: With conv_en=1 and sub_mode=0, every BCD digit 0..9 on a_in gives its Excess-3 code (digit + 3, i.e. 0011..1100) with flag 0.
- R6: With conv_en=1 and sub_mode=1, every Excess-3 code 0011..1100 on a_in gives its BCD digit 0..9 with flag 0.
- R7: With conv_en=1, codes outside the valid range give the plain arithmetic result: (a_in + 3) mod 16 with flag set for a_in of 13 and above when adding, and (a_in - 3) mod 16 with flag set for a_in of 2 and below when subtracting. No separate error indication exists.
- R8: With conv_en=1, b_in has no effect on result or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 4 | First operand, or the code to convert |
| b_in | input | 4 | Second operand, ignored while conv_en is high |
| sub_mode | input | 1 | 0 = add, 1 = subtract (two's complement) |
| conv_en | input | 1 | 1 = replace the second operand with 0011 |
| result | output | 4 | Sum or difference, modulo 16 |
| flag | output | 1 | Carry-out when adding, borrow (a_in below operand) when subtracting |

## Verification
The hardest case to reach is one where the carry ripples through every stage while the flag must read as a borrow, not a carry. Examples are subtracting an equal value, which gives a full-length carry and flag 0, and subtracting a larger value, which gives no carry and flag 1. These cases are covered by an exhaustive sweep of all operand and mode pairs. Conversion is driven with every valid code in both directions and every out-of-range code. Random b_in values are applied while conversion is selected, to show that the second operand is ignored.

// File: rtl/nibble_addsub_pkg.sv
package nibble_addsub_pkg;
  parameter int unsigned DATA_W = 4;
  parameter int unsigned CONV_K = 3;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction
endpackage

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] K = 3
) (
  input  logic [W-1:0] b_raw,
  input  logic         use_const,
  input  logic         invert,
  output logic [W-1:0] b_chosen,
  output logic [W-1:0] b_to_adder
);
  always_comb b_chosen = use_const ? K : b_raw;

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign b_to_adder[i] = b_chosen[i] ^ invert;
  end

  // R8: with the constant selected, what reaches the adder does not track b_raw
  always_comb begin
    if (use_const) begin
      a_r8_const_operand: assert ((b_to_adder ^ {W{invert}}) == K);
    end
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple
  import nibble_addsub_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  localparam int unsigned CW = W + 1;
  logic [CW-1:0] c;

  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_stage
    assign s[i]   = fa_sum(x[i], y[i], c[i]);
    assign c[i+1] = fa_carry(x[i], y[i], c[i]);
  end
  assign cout = c[W];

  // R1: the chain of full adders behaves as one wide adder
  always_comb begin
    a_r1_chain_sum: assert ({cout, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}));
  end
endmodule

// File: rtl/nibble_addsub_conv.sv
module nibble_addsub_conv
  import nibble_addsub_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  parameter int unsigned K = CONV_K
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sub_mode,
  input  logic         conv_en,
  output logic [W-1:0] result,
  output logic         flag
);
  localparam logic [W-1:0] KV = W'(K);

  logic [W-1:0] b_chosen;
  logic [W-1:0] b_to_adder;
  logic         raw_carry;

  addsub_operand_sel #(.W(W), .K(KV)) u_opsel (
    .b_raw     (b_in),
    .use_const (conv_en),
    .invert    (sub_mode),
    .b_chosen  (b_chosen),
    .b_to_adder(b_to_adder)
  );

  addsub_ripple #(.W(W)) u_add (
    .x   (a_in),
    .y   (b_to_adder),
    .cin (sub_mode),
    .s   (result),
    .cout(raw_carry)
  );

  assign flag = raw_carry ^ sub_mode;

  always_comb begin
    // R2: difference added back to the subtrahend restores the minuend
    if (sub_mode) begin
      a_r2_diff_inverse: assert (W'(result + b_chosen) == a_in);
    end
    // R3: borrow reads as an unsigned less-than
    if (sub_mode) begin
      a_r3_borrow_lt: assert (flag == (a_in < b_chosen));
    end
    // R5: BCD digit lands inside the Excess-3 range
    if (conv_en && !sub_mode && a_in <= W'(9)) begin
      a_r5_to_xs3: assert (result >= KV && result <= W'(9 + K) && !flag);
    end
    // R6: Excess-3 code lands on a BCD digit
    if (conv_en && sub_mode && a_in >= KV && a_in <= W'(9 + K)) begin
      a_r6_to_bcd: assert (result <= W'(9) && !flag);
    end
  end
endmodule

// File: tb/nibble_addsub_conv_tb.sv
module nibble_addsub_conv_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [3:0] a_in, b_in, result;
  logic sub_mode, conv_en, flag;
  int unsigned n_tests = 0, n_fail = 0;
  bit done = 0;

  nibble_addsub_conv u_dut (
    .a_in(a_in), .b_in(b_in), .sub_mode(sub_mode), .conv_en(conv_en),
    .result(result), .flag(flag)
  );

  function automatic logic [4:0] ref_model(input int a, input int b, input bit m, input bit c);
    int opd;
    int r;
    opd = c ? 3 : b;
    if (m) begin
      r = a - opd;
      return {(a < opd) ? 1'b1 : 1'b0, 4'(r & 15)};
    end
    r = a + opd;
    return {(r > 15) ? 1'b1 : 1'b0, 4'(r & 15)};
  endfunction

  task automatic run(input int a, input int b, input bit m, input bit c,
                     input string req, input logic [4:0] want);
    @(negedge clk);
    a_in = 4'(a); b_in = 4'(b); sub_mode = m; conv_en = c;
    #2;
    n_tests++;
    if ({flag, result} !== want) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d m=%0b c=%0b actual flag=%0b res=%b expected flag=%0b res=%b",
               req, a, b, m, c, flag, result, want[4], want[3:0]);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    a_in = 0; b_in = 0; sub_mode = 0; conv_en = 0;
    run(0, 0, 0, 0, "R1 idle", 5'b0_0000);
    // R4 directed example
    run(14, 15, 1, 0, "R4", 5'b1_1111);
    // R3 corners: equal and one-larger
    run(9, 9, 1, 0, "R3", 5'b0_0000);
    run(0, 15, 1, 0, "R3", 5'b1_0001);
    run(15, 1, 0, 0, "R1", 5'b1_0000);
    // R1 R2 R3 exhaustive
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run(a, b, m[0], 0, m ? "R2/R3" : "R1", ref_model(a, b, m[0], 0));
    // R5 BCD -> Excess-3
    for (int d = 0; d < 10; d++) run(d, 0, 0, 1, "R5", {1'b0, 4'(d + 3)});
    // R6 Excess-3 -> BCD
    for (int e = 3; e < 13; e++) run(e, 0, 1, 1, "R6", {1'b0, 4'(e - 3)});
    // R7 out-of-range codes
    for (int a = 10; a < 16; a++) run(a, 0, 0, 1, "R7", ref_model(a, 0, 0, 1));
    for (int a = 0; a < 3; a++)   run(a, 0, 1, 1, "R7", ref_model(a, 0, 1, 1));
    for (int a = 13; a < 16; a++) run(a, 0, 1, 1, "R7", ref_model(a, 0, 1, 1));
    run(13, 0, 0, 1, "R7", 5'b1_0000);
    run(2, 0, 1, 1, "R7", 5'b1_1111);
    // R8 random b_in under conversion
    for (int i = 0; i < 300; i++) begin
      int a = int'($urandom_range(15));
      int b = int'($urandom_range(15));
      bit m = 1'($urandom_range(1));
      run(a, b, m, 1, "R8", ref_model(a, 0, m, 1));
    end
    // random mix
    for (int i = 0; i < 300; i++) begin
      int a = int'($urandom_range(15));
      int b = int'($urandom_range(15));
      bit m = 1'($urandom_range(1));
      bit c = 1'($urandom_range(1));
      run(a, b, m, c, "R1/R2/R8 random", ref_model(a, b, m, c));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule